// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Error Flag

This block moves data words from one clock domain to another. Words enter on the write clock through a valid/ready handshake and leave on the read clock through a request/response port. Storage is a power-of-two array. The write pointer and the read pointer are each kept in binary and in Gray code. Each pointer crosses into the other domain as a Gray code through a two-flop synchronizer. As a result, the full, almost-full and empty flags are conservative: each can stay set for the synchronizer latency after the other side has moved.

Back-pressure on the write side works as follows:
- `wr_ready` is the inverse of `full`.
- A word is stored only on a write-clock edge at which both `wr_valid` and `wr_ready` are high.
- A word offered while `wr_ready` is low is dropped and is never stored.
- Offering a word while `wr_ready` is low raises the registered `wr_err` flag. This lets a producer that ignores back-pressure see that it lost data.

On the read side, a request made while the FIFO is not empty returns the oldest word one read-clock cycle later, together with `rd_data_valid`. A request made while empty is ignored.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the read port in exactly the order in which they were accepted on the write port, with no word lost or repeated.
- R2: `full` rises on the write-clock edge that stores the last free entry (DEPTH words held), and `wr_ready` equals the inverse of `full` at all times.
- R3: A word offered with `wr_valid` high while `full` is high is not stored. Later reads never return it, and the write pointer does not move.
- R4: `almost_full` is updated on every write-clock edge. After each edge it is high exactly when the fill level seen on the write side (words written minus reads already synchronized) is at least AFULL_LVL, which defaults to DEPTH-2.
- R5: `wr_err` is high after every write-clock edge at which `wr_valid` and `full` were both high, so it stays high for as long as both stay high.
- R6: `wr_err` goes low after the first write-clock edge at which `wr_valid` is low.
- R7: When the FIFO is full, a read followed, before that read has crossed the synchronizer, by a write attempt leaves `full` high. The write is rejected. `full` falls once the read has been synchronized (within four write-clock cycles).
- R8: A read request while `empty` is high is ignored: `rd_data_valid` stays low and the read pointer does not move.
- R9: An accepted read request (`rd_req` high and `empty` low) gives `rd_data_valid` high with the oldest word on `rd_data` after the next read-clock edge.
- R10: While `rst_n` is low, both pointers are cleared, `empty` is high, and `full`, `almost_full`, `wr_err` and `rd_data_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write side can accept a word (inverse of full) |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | All entries occupied as seen by the write side |
| almost_full | output | 1 | Fill level at or above AFULL_LVL |
| wr_err | output | 1 | A write was attempted while full on the previous edge |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Word returned by an accepted read |
| rd_data_valid | output | 1 | rd_data holds a word from the previous accepted read |
| empty | output | 1 | No word visible to the read side |

## Verification
A corrupted write pointer or a broken Gray conversion shows first in the flags. Within a few write cycles, `full` or `almost_full` comes up at the wrong fill level. On the read side, `empty` stays set or clears too early, which then yields out-of-order or stale words at the next read. A corrupted read pointer shows at the next accepted read: `rd_data` no longer matches the reference queue. A wrong full-compare lets a dropped word into storage, and the drain at the end of the scenario exposes it. Faulty error logic is visible one write edge after the offending `wr_valid` level.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g, input int w);
    logic [31:0] b;
    b = '0;
    for (int i = 31; i >= 0; i--) begin
      if (i < w) begin
        b[i] = g[i] ^ ((i == w - 1) ? 1'b0 : b[i + 1]);
      end
    end
    return b;
  endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/xclk_fifo_wr_ctrl.sv
module xclk_fifo_wr_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int AFULL_LVL = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [ADDR_W:0] rq_gray,
  output logic            push,
  output logic [ADDR_W:0] ptr_bin,
  output logic [ADDR_W:0] ptr_gray,
  output logic            full,
  output logic            almost_full,
  output logic            err
);
  localparam int PW = ADDR_W + 1;

  logic [ADDR_W:0] bin_nxt, gray_nxt, rq_bin, fill_nxt, full_cmp;
  logic [31:0]     conv;

  assign push     = valid && !full;
  assign bin_nxt  = ptr_bin + {{ADDR_W{1'b0}}, push};
  assign gray_nxt = PW'(to_gray(32'(bin_nxt)));
  assign conv     = from_gray(32'(rq_gray), PW);
  assign rq_bin   = conv[ADDR_W:0];
  assign fill_nxt = bin_nxt - rq_bin;
  assign full_cmp = {~rq_gray[ADDR_W:ADDR_W-1], rq_gray[ADDR_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin     <= '0;
      ptr_gray    <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      err         <= 1'b0;
    end else begin
      ptr_bin     <= bin_nxt;
      ptr_gray    <= gray_nxt;
      full        <= (gray_nxt == full_cmp);
      almost_full <= (fill_nxt >= PW'(AFULL_LVL));
      err         <= valid && full;
    end
  end
endmodule

// File: rtl/xclk_fifo_rd_ctrl.sv
module xclk_fifo_rd_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [ADDR_W:0] wq_gray,
  output logic            pop,
  output logic [ADDR_W:0] ptr_bin,
  output logic [ADDR_W:0] ptr_gray,
  output logic            empty,
  output logic            data_valid
);
  localparam int PW = ADDR_W + 1;

  logic [ADDR_W:0] bin_nxt, gray_nxt;

  assign pop      = req && !empty;
  assign bin_nxt  = ptr_bin + {{ADDR_W{1'b0}}, pop};
  assign gray_nxt = PW'(to_gray(32'(bin_nxt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin    <= '0;
      ptr_gray   <= '0;
      empty      <= 1'b1;
      data_valid <= 1'b0;
    end else begin
      ptr_bin    <= bin_nxt;
      ptr_gray   <= gray_nxt;
      empty      <= (gray_nxt == wq_gray);
      data_valid <= pop;
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int AFULL_LVL = (1 << ADDR_W) - 2,
  parameter int SYNC_STG  = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  output logic              wr_err,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_valid,
  output logic              empty
);
  logic            push, pop;
  logic [ADDR_W:0] w_bin, w_gray, r_bin, r_gray, rq_gray, wq_gray;

  xclk_fifo_wr_ctrl #(.ADDR_W(ADDR_W), .AFULL_LVL(AFULL_LVL)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .valid(wr_valid), .rq_gray(rq_gray),
    .push(push), .ptr_bin(w_bin), .ptr_gray(w_gray), .full(full),
    .almost_full(almost_full), .err(wr_err)
  );

  xclk_fifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .req(rd_req), .wq_gray(wq_gray),
    .pop(pop), .ptr_bin(r_bin), .ptr_gray(r_gray), .empty(empty),
    .data_valid(rd_data_valid)
  );

  xclk_fifo_sync #(.W(ADDR_W + 1), .STAGES(SYNC_STG)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(r_gray), .q(rq_gray)
  );

  xclk_fifo_sync #(.W(ADDR_W + 1), .STAGES(SYNC_STG)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(w_gray), .q(wq_gray)
  );

  xclk_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .wr_en(push), .wr_addr(w_bin[ADDR_W-1:0]), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_en(pop), .rd_addr(r_bin[ADDR_W-1:0]), .rd_data(rd_data)
  );

  assign wr_ready = !full;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int ADDR_W = 4
) (
  input logic            wr_clk,
  input logic            rd_clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            full,
  input logic            almost_full,
  input logic            wr_err,
  input logic [ADDR_W:0] w_bin,
  input logic [ADDR_W:0] w_gray,
  input logic            rd_req,
  input logic            empty,
  input logic            rd_data_valid,
  input logic [ADDR_W:0] r_bin
);
  // R3
  ovf_discard_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_valid && full) |=> $stable(w_bin));
  // R5
  werr_set_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_valid && full) |=> wr_err);
  // R6
  werr_clr_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_valid |=> !wr_err);
  // R2
  full_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> almost_full);
  // R8
  empty_read_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_req && empty) |=> (!rd_data_valid && $stable(r_bin)));
  // R9
  read_resp_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_req && !empty) |=> rd_data_valid);
  // R1
  gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);
endmodule

bind xclk_fifo xclk_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wr_valid),
  .full(full), .almost_full(almost_full), .wr_err(wr_err), .w_bin(w_bin),
  .w_gray(w_gray), .rd_req(rd_req), .empty(empty),
  .rd_data_valid(rd_data_valid), .r_bin(r_bin)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AFL = DEPTH - 2;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, full, almost_full, wr_err, rd_data_valid, empty;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] refq[$];

  always #2.5 wr_clk = ~wr_clk;
  always #3.7 rd_clk = ~rd_clk;

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_xclk_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .wr_err(wr_err), .rd_req(rd_req), .rd_data(rd_data),
    .rd_data_valid(rd_data_valid), .empty(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  // one write attempt; queue updated only if accepted
  task automatic wr_one(input logic [DW-1:0] d);
    @(negedge wr_clk);
    chk("R2", wr_ready, !full);
    if (!full) refq.push_back(d);
    wr_valid = 1; wr_data = d;
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  // one read of the oldest word, waiting for data to be visible
  task automatic rd_one(input string req);
    logic [DW-1:0] e;
    @(negedge rd_clk);
    while (empty) @(negedge rd_clk);
    rd_req = 1;
    @(negedge rd_clk);
    rd_req = 0;
    e = refq.pop_front();
    chk("R9", rd_data_valid, 1);
    chk(req, rd_data, e);
  endtask

  task automatic t_reset();
    #1;
    chk("R10", empty, 1); chk("R10", full, 0); chk("R10", almost_full, 0);
    chk("R10", wr_err, 0); chk("R10", rd_data_valid, 0);
  endtask

  task automatic t_empty_read();
    for (int i = 0; i < 3; i++) begin
      @(negedge rd_clk); rd_req = 1;
      @(negedge rd_clk); rd_req = 0;
      chk("R8", rd_data_valid, 0);
      chk("R8", empty, 1);
    end
    wr_one(8'hA5);
    settle();
    rd_one("R8");   // pointer unmoved: first word still returned
    settle();
    chk("R8", empty, 1);
  endtask

  task automatic t_fill_overflow();
    for (int k = 1; k <= DEPTH; k++) begin
      wr_one(8'(8'h10 + k));
      chk("R4", almost_full, (k >= AFL));
      chk("R2", full, (k == DEPTH));
    end
    // offer two more while full
    @(negedge wr_clk); wr_valid = 1; wr_data = 8'hEE;
    @(negedge wr_clk); chk("R5", wr_err, 1); chk("R3", full, 1);
    wr_data = 8'hEF;
    @(negedge wr_clk); chk("R5", wr_err, 1);
    wr_valid = 0;
    @(negedge wr_clk); chk("R6", wr_err, 0);
  endtask

  task automatic t_read_then_write();
    rd_one("R1");
    wr_one(8'hDD);   // attempted before the read crosses over
    chk("R7", full, 1);
    chk("R7", wr_err, 1);
    repeat (4) @(negedge wr_clk);
    chk("R7", full, 0);
    while (refq.size() > 0) rd_one("R3");
    settle();
    chk("R3", empty, 1);
  endtask

  task automatic t_stream();
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          @(negedge wr_clk);
          while (full) @(negedge wr_clk);
          refq.push_back(8'(i * 7 + 3));
          wr_valid = 1; wr_data = 8'(i * 7 + 3);
          @(negedge wr_clk); wr_valid = 0;
        end
      end
      begin
        for (int i = 0; i < 60; i++) rd_one("R1");
      end
    join
    settle();
    chk("R1", empty, 1);
  endtask

  initial begin
    #20;
    t_reset();
    rst_n = 1;
    settle();
    t_empty_read();
    t_fill_overflow();
    t_read_then_write();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule